// File: doc/BRIEF.md
# Rotating-Priority Physical Register Free List

This block tracks which entries of a physical register file may be handed to newly renamed instructions. One bit per register records availability. Register 0 always reads as zero, so it is never handed out. At any time the block offers one free register at its output. A rename stage takes that register by raising its request while the offer is valid. A single return port puts registers back when an instruction commits (the mapping it replaced) or is squashed (the mapping it created). There is no checkpoint restore: squashed work returns its registers one at a time.

The search for the next register does not always favour the lowest index. It runs in a circle, starting just above the register granted most recently. Grants therefore sweep upward through the file, and a register that has just come back waits until the sweep wraps around before it is offered again. The circular search is built by rotating the availability map, running an ordinary lowest-bit priority encoder, and mapping the winning position back to a register number. A parameter chooses one of two ways to do that last step: an add followed by a conditional subtract, or a rotated table of index constants.

Top module: `preg_free_list`

## Requirements
- R1: During and after a synchronous active-high reset, registers 1 to FIRST_FREE-1 (default 31) are held busy and FIRST_FREE to NUM_PREGS-1 (default 32 to 63) are free. In the first cycle after reset, `alloc_ready` is 1 and `alloc_preg` is FIRST_FREE (32).
- R2: Register 0 is never offered. A return of index 0 on the free port has no effect.
- R3: The offered register is the first free one found by a circular search. The search starts at the current start point, counts upward to NUM_PREGS-1, wraps to register 1, and ends just below the start point.
- R4: After a grant of register r, the start point becomes r+1, or register 1 when r is NUM_PREGS-1. A register returned behind the start point is not offered before the search wraps past it.
- R5: When no register is free, `alloc_ready` is 0. A request made while `alloc_ready` is 0 grants nothing and changes no state.
- R6: A return on the free port makes the register available. Returning a register that is already free leaves exactly one free copy of it.
- R7: A grant and a return in the same cycle both take effect.
- R8: A grant happens at a rising edge where `alloc_req` and `alloc_ready` are both 1. The offer for the updated state appears on the registered outputs in the next cycle.
- R9: Both search variants (SRCH_ADD_WRAP and SRCH_IDX_ROTATE) produce identical `alloc_ready` and `alloc_preg` for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Take the currently offered register |
| alloc_ready | output | 1 | Registered: an offer is valid |
| alloc_preg | output | $clog2(NUM_PREGS) | Registered: offered physical register |
| free_valid | input | 1 | Return a register this cycle |
| free_preg | input | $clog2(NUM_PREGS) | Register being returned |

## Verification
Every result is due exactly one rising edge after its stimulus. A grant or a return sampled at edge E is reflected in `alloc_ready` and `alloc_preg` just after E, because the next offer is computed from the updated map and start point and then registered. The bench drives inputs on the falling edge, lets one rising edge pass, and reads the outputs at the following falling edge. Each scenario task therefore compares every offer against a value computed by hand from the circular-search rule, including the offers that follow a wrap, a return behind the start point, and an empty list.

// File: rtl/preg_fl_pkg.sv
package preg_fl_pkg;

  // how a rotated priority-encoder position is turned back into a map slot
  typedef enum logic [0:0] {
    SRCH_ADD_WRAP   = 1'b0,  // add start point, subtract map size on overflow
    SRCH_IDX_ROTATE = 1'b1   // rotate a table of slot numbers alongside the map
  } srch_variant_e;

endpackage

// File: rtl/fl_avail_map.sv
module fl_avail_map #(
  parameter int N          = 63,
  parameter int IW         = 6,
  parameter int FIRST_FREE = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_slot,
  input  logic          set_en,
  input  logic [IW-1:0] set_slot,
  output logic [N-1:0]  map_q,
  output logic [N-1:0]  map_next
);

  // slot i stands for physical register i+1
  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam logic RST_FREE = ((i + 1) >= FIRST_FREE);
    logic hit_clr, hit_set;
    assign hit_clr = clr_en && (clr_slot == IW'(i));
    assign hit_set = set_en && (set_slot == IW'(i));
    assign map_next[i] = (map_q[i] & ~hit_clr) | hit_set;

    always_ff @(posedge clk) begin
      if (rst) map_q[i] <= RST_FREE;
      else     map_q[i] <= map_next[i];
    end
  end

  // R6: a returned slot is free on the next cycle
  p_set_lands_r6: assert property (@(posedge clk) disable iff (rst)
    set_en |=> map_q[$past(set_slot)]);

endmodule

// File: rtl/fl_start_ptr.sv
module fl_start_ptr #(
  parameter int N  = 63,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [IW-1:0] won_slot,
  output logic [IW-1:0] start_q,
  output logic [IW-1:0] start_next
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_comb begin
    start_next = start_q;
    if (adv) start_next = (won_slot == LAST) ? '0 : won_slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= '0;
    else     start_q <= start_next;
  end

  // R4: start point never leaves the map
  p_start_range_r4: assert property (@(posedge clk) disable iff (rst)
    start_q <= LAST);

endmodule

// File: rtl/fl_rot_search.sv
module fl_rot_search
  import preg_fl_pkg::*;
#(
  parameter int            N       = 63,
  parameter int            IW      = 6,
  parameter srch_variant_e VARIANT = SRCH_ADD_WRAP
) (
  input  logic [N-1:0]  avail,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] slot
);

  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [IW-1:0]  pos;

  assign dbl = {avail, avail};
  assign rot = dbl[start +: N];

  // plain lowest-position priority encoder on the rotated map
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) begin
        pos   = IW'(i);
        found = 1'b1;
      end
    end
  end

  if (VARIANT == SRCH_ADD_WRAP) begin : g_add_wrap
    localparam logic [IW:0] NW = (IW + 1)'(N);
    logic [IW:0] sum;
    logic [IW:0] wrapped;
    assign sum     = {1'b0, pos} + {1'b0, start};
    assign wrapped = sum - NW;
    assign slot    = (sum >= NW) ? wrapped[IW-1:0] : sum[IW-1:0];
  end else begin : g_idx_rotate
    logic [IW-1:0] dtab    [2*N];
    logic [IW-1:0] rot_idx [N];
    for (genvar j = 0; j < 2 * N; j++) begin : g_tab
      assign dtab[j] = IW'(j % N);
    end
    for (genvar i = 0; i < N; i++) begin : g_rot
      logic [IW:0] sel;
      assign sel        = {1'b0, start} + (IW + 1)'(i);
      assign rot_idx[i] = dtab[sel];
    end
    assign slot = rot_idx[pos];
  end

endmodule

// File: rtl/preg_free_list.sv
module preg_free_list
  import preg_fl_pkg::*;
#(
  parameter int            NUM_PREGS    = 64,
  parameter int            FIRST_FREE   = 32,
  parameter srch_variant_e SRCH_VARIANT = SRCH_ADD_WRAP
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_req,
  output logic                         alloc_ready,
  output logic [$clog2(NUM_PREGS)-1:0] alloc_preg,
  input  logic                         free_valid,
  input  logic [$clog2(NUM_PREGS)-1:0] free_preg
);

  localparam int N  = NUM_PREGS - 1;        // register 0 is not in the map
  localparam int IW = $clog2(NUM_PREGS);
  localparam logic          RST_READY = (FIRST_FREE < NUM_PREGS);
  localparam logic [IW-1:0] RST_OFFER = IW'(FIRST_FREE);
  localparam logic [IW-1:0] TOP_PREG  = IW'(NUM_PREGS - 1);

  logic          ready_q;
  logic [IW-1:0] offer_q;
  logic          grant;
  logic [IW-1:0] grant_slot;
  logic          free_ok;
  logic [IW-1:0] free_slot;
  logic [N-1:0]  map_q, map_next;
  logic [IW-1:0] start_q, start_next;
  logic          found;
  logic [IW-1:0] hit_slot;

  assign grant      = alloc_req && ready_q;
  assign grant_slot = offer_q - 1'b1;
  assign free_ok    = free_valid && (free_preg != '0) &&
                      ({1'b0, free_preg} < (IW + 1)'(NUM_PREGS));
  assign free_slot  = free_preg - 1'b1;

  fl_avail_map #(.N(N), .IW(IW), .FIRST_FREE(FIRST_FREE)) u_map (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (grant),
    .clr_slot (grant_slot),
    .set_en   (free_ok),
    .set_slot (free_slot),
    .map_q    (map_q),
    .map_next (map_next)
  );

  fl_start_ptr #(.N(N), .IW(IW)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .adv        (grant),
    .won_slot   (grant_slot),
    .start_q    (start_q),
    .start_next (start_next)
  );

  fl_rot_search #(.N(N), .IW(IW), .VARIANT(SRCH_VARIANT)) u_search (
    .avail (map_next),
    .start (start_next),
    .found (found),
    .slot  (hit_slot)
  );

  // offer for the post-update state, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= RST_READY;
      offer_q <= RST_OFFER;
    end else begin
      ready_q <= found;
      offer_q <= hit_slot + 1'b1;
    end
  end

  assign alloc_ready = ready_q;
  assign alloc_preg  = offer_q;

  // R2: register 0 never offered
  p_no_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (offer_q != '0));

  // R3: the offered register really is free in the map
  p_offer_free_r3: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> map_q[grant_slot]);

  // R5: no offer only when the map is empty
  p_empty_stall_r5: assert property (@(posedge clk) disable iff (rst)
    !ready_q |-> (map_q == '0));

  // R4: start point follows the last grant
  p_ptr_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (grant && offer_q != TOP_PREG) |=> (start_q == $past(offer_q)));
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (grant && offer_q == TOP_PREG) |=> (start_q == '0));

  // R7: a grant removes the register unless it is returned in the same cycle
  p_grant_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (grant && !(free_ok && free_slot == grant_slot)) |=> !map_q[$past(grant_slot)]);

endmodule

// File: tb/preg_free_list_bench.sv
module preg_free_list_bench;
  import preg_fl_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alloc_req = 1'b0;
  logic       free_valid = 1'b0;
  logic [5:0] free_preg = '0;
  logic       alloc_ready, alt_ready;
  logic [5:0] alloc_preg, alt_preg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  preg_free_list #(.SRCH_VARIANT(SRCH_ADD_WRAP)) u_preg_free_list (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_ready(alloc_ready),
    .alloc_preg(alloc_preg), .free_valid(free_valid), .free_preg(free_preg));

  preg_free_list #(.SRCH_VARIANT(SRCH_IDX_ROTATE)) u_preg_free_list_idxrot (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_ready(alt_ready),
    .alloc_preg(alt_preg), .free_valid(free_valid), .free_preg(free_preg));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R9: the two search variants agree; R1..R8 on the offer
  task automatic expect_offer(input string req, input int rdy, input int preg);
    check({req, " ready"}, int'(alloc_ready), rdy);
    if (rdy != 0) check({req, " preg"}, int'(alloc_preg), preg);
    check("R9 ready match", int'(alt_ready), int'(alloc_ready));
    check("R9 preg match", int'(alt_preg), int'(alloc_preg));
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic req, input logic fv, input int fp);
    alloc_req  = req;
    free_valid = fv;
    free_preg  = 6'(fp);
    @(posedge clk);
    @(negedge clk);
    alloc_req  = 1'b0;
    free_valid = 1'b0;
    free_preg  = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_offer("R1 reset", 1, 32);
    step(1'b0, 1'b0, 0);
    expect_offer("R1 idle hold", 1, 32);
  endtask

  task automatic t_drain();
    do_reset();
    for (int r = 32; r < 63; r++) begin
      expect_offer("R3 sweep", 1, r);
      step(1'b1, 1'b0, 0);
    end
    expect_offer("R3 last", 1, 63);
    step(1'b1, 1'b1, 20);                 // grant 63 and return 20 together
    expect_offer("R7 same-cycle", 1, 20);
    step(1'b1, 1'b0, 0);
    expect_offer("R5 empty", 0, 0);
    step(1'b1, 1'b0, 0);
    step(1'b1, 1'b0, 0);
    expect_offer("R5 req when empty", 0, 0);
    step(1'b0, 1'b1, 0);
    expect_offer("R2 free zero ignored", 0, 0);
    step(1'b0, 1'b1, 45);
    expect_offer("R6 return", 1, 45);
    step(1'b0, 1'b1, 45);
    expect_offer("R6 double return", 1, 45);
    step(1'b1, 1'b0, 0);
    expect_offer("R6 single copy", 0, 0);
  endtask

  task automatic t_no_reuse();
    do_reset();
    step(1'b1, 1'b0, 0);
    expect_offer("R8 next offer", 1, 33);
    step(1'b0, 1'b1, 32);
    expect_offer("R4 no reuse", 1, 33);
    step(1'b1, 1'b0, 0);
    expect_offer("R4 sweep on", 1, 34);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int r = 32; r < 63; r++) step(1'b1, 1'b0, 0);
    step(1'b0, 1'b1, 5);
    step(1'b0, 1'b1, 50);
    expect_offer("R3 from start", 1, 63);
    step(1'b1, 1'b0, 0);
    expect_offer("R3 wrap", 1, 5);
    step(1'b1, 1'b0, 0);
    expect_offer("R4 after wrap", 1, 50);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_drain();
    t_no_reuse();
    t_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule